// File: doc/BRIEF.md
# AHCI Port Software-Reset Sequencer

This block follows the software-reset handshake of a single SATA port from the host side. Each host-to-device register FIS that the command engine submits arrives here as one strobe. The strobe carries the FIS device-control byte, the command slot it came from, and the clear-busy flag of that slot's command header. The block keeps the port in either a running state or a reset state. It clears command-issue bits at the points the reset protocol requires, and it puts the port registers back to their power-on values once the reset completes.

Device-to-host register FIS arrivals are presented as a second strobe that carries the task-file fields. The first such arrival after any port reset is the device's power-up report. It supplies the port signature, it does not complete any command, and it is handled the same way whether a COMRESET or the set/clear control sequence caused the reset. Every later arrival updates the task-file register and retires the slot that is marked busy. Software command issue enters through a bit-mask input.

Top module: `ahci_srst_seq`

## Requirements
- R1: After `rst_n` is released the port is running (`in_reset`=0), `ci`=0, `tfd`=0x007F, `sig`=0xFFFFFFFF, `busy_valid`=0 and `d2h_sent`=0.
- R2: While running, an H2D strobe whose control byte has bit 2 (value 0x04) set puts the port in reset from the next cycle on. A control byte with only other bits set leaves it running.
- R3: On the H2D strobe that enters reset, the `ci` bit of `h2d_slot` is cleared if `h2d_clr_busy` is 1. If `h2d_clr_busy` is 0, `ci` is left as it was.
- R4: While in reset, an H2D strobe with control bit 2 clear performs a port reset. The port returns to running with `ci`=0, `tfd`=0x007F, `sig`=0xFFFFFFFF, `busy_valid`=0 and `d2h_sent`=0.
- R5: While in reset, an H2D strobe with control bit 2 set is ignored. The port stays in reset and `ci` is unchanged, even when `h2d_clr_busy` is 1.
- R6: The first D2H strobe after a port reset loads `sig` as {cyl_hi, cyl_lo, lba_lo, count} (bits 31:24, 23:16, 15:8, 7:0), loads `tfd` as {error, status}, and sets `d2h_sent`. It leaves `ci` and the busy slot unchanged.
- R7: A D2H strobe while `d2h_sent`=1 loads `tfd`, leaves `sig` unchanged, clears the `ci` bit of the busy slot and clears `busy_valid`.
- R8: A `comreset` pulse performs the same port reset as R4 from either state. After it, R6 applies to the next D2H strobe.
- R9: While running, an H2D strobe with control bit 2 clear marks its slot busy (`busy_valid`=1, `busy_slot`=`h2d_slot`).
- R10: `ci_set` bits are ORed into `ci`. When an issue and a reset-entry clear fall in the same cycle, both take effect. A port reset in the same cycle drops the issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| comreset | input | 1 | Link-level port reset event |
| h2d_valid | input | 1 | H2D register FIS submitted this cycle |
| h2d_ctrl | input | 8 | Device-control byte of that FIS |
| h2d_slot | input | SLOT_W | Command slot of that FIS |
| h2d_clr_busy | input | 1 | Header flag: clear busy on R_OK |
| ci_set | input | NUM_SLOTS | Software command-issue mask |
| d2h_valid | input | 1 | D2H register FIS received this cycle |
| d2h_status | input | 8 | Status field |
| d2h_error | input | 8 | Error field |
| d2h_cyl_hi | input | 8 | Cylinder-high field |
| d2h_cyl_lo | input | 8 | Cylinder-low field |
| d2h_lba_lo | input | 8 | LBA-low field |
| d2h_count | input | 8 | Sector-count field |
| ci | output | NUM_SLOTS | Command-issue register |
| tfd | output | 16 | Task-file data {error, status} |
| sig | output | 32 | Device signature |
| busy_valid | output | 1 | A slot is busy |
| busy_slot | output | SLOT_W | The busy slot |
| d2h_sent | output | 1 | Initial D2H report received |
| in_reset | output | 1 | Port is in software reset |

## Verification
Two kinds of collision matter here. The first is a software issue landing in the same cycle as the reset-entry clear of a different slot. The bench drives `ci_set` on the same edge as the SRST-set FIS and expects the issued bit set and the cleared bit gone. The second is an issue that coincides with the reset-releasing FIS. For that case the bench expects `ci` to read zero, because the port reset takes precedence. A D2H strobe arriving right after a reset is also checked to confirm that it fills the signature without retiring the busy slot.

// File: rtl/ahci_srst_pkg.sv
package ahci_srst_pkg;
    typedef enum logic {
        PS_RUN = 1'b0,
        PS_RST = 1'b1
    } port_state_e;

    localparam int unsigned CTRL_SRST_BIT = 2;
    localparam logic [15:0] TFD_INIT      = 16'h007F;
    localparam logic [31:0] SIG_INIT      = 32'hFFFF_FFFF;
endpackage

// File: rtl/ahci_srst_fsm.sv
module ahci_srst_fsm
    import ahci_srst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic comreset,
    input  logic fis_valid,
    input  logic srst_bit,
    input  logic clr_busy,
    output logic enter_rst,
    output logic port_rst,
    output logic clr_req,
    output logic cmd_mark,
    output logic in_reset
);
    typedef struct packed {
        port_state_e st;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        enter_rst = (s_q.st == PS_RUN) && fis_valid && srst_bit && !comreset;
        cmd_mark  = (s_q.st == PS_RUN) && fis_valid && !srst_bit && !comreset;
        clr_req   = enter_rst && clr_busy;
        port_rst  = comreset || ((s_q.st == PS_RST) && fis_valid && !srst_bit);
        if (port_rst) begin
            s_d.st = PS_RUN;
        end else if (enter_rst) begin
            s_d.st = PS_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: PS_RUN};
        else        s_q <= s_d;
    end

    assign in_reset = (s_q.st == PS_RST);
endmodule

// File: rtl/ahci_srst_slots.sv
module ahci_srst_slots #(
    parameter int unsigned NUM_SLOTS = 32,
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_rst,
    input  logic                 clr_req,
    input  logic                 cmd_mark,
    input  logic                 d2h_done,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [NUM_SLOTS-1:0] issue,
    output logic [NUM_SLOTS-1:0] ci,
    output logic                 busy_valid,
    output logic [SLOT_W-1:0]    busy_slot
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] ci;
        logic                 bvld;
        logic [SLOT_W-1:0]    bslot;
    } slots_t;

    slots_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (d2h_done && r_q.bvld) begin
            r_d.ci[r_q.bslot] = 1'b0;
            r_d.bvld          = 1'b0;
        end
        if (clr_req) begin
            r_d.ci[slot] = 1'b0;
        end
        if (cmd_mark) begin
            r_d.bvld  = 1'b1;
            r_d.bslot = slot;
        end
        r_d.ci = r_d.ci | issue;
        if (port_rst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ci         = r_q.ci;
    assign busy_valid = r_q.bvld;
    assign busy_slot  = r_q.bslot;
endmodule

// File: rtl/ahci_srst_sigcap.sv
module ahci_srst_sigcap
    import ahci_srst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_rst,
    input  logic        d2h_valid,
    input  logic [7:0]  f_status,
    input  logic [7:0]  f_error,
    input  logic [7:0]  f_cyl_hi,
    input  logic [7:0]  f_cyl_lo,
    input  logic [7:0]  f_lba_lo,
    input  logic [7:0]  f_count,
    output logic        d2h_done,
    output logic [15:0] tfd,
    output logic [31:0] sig,
    output logic        d2h_sent
);
    typedef struct packed {
        logic [15:0] tfd;
        logic [31:0] sig;
        logic        sent;
    } cap_t;

    localparam cap_t CAP_INIT = '{tfd: TFD_INIT, sig: SIG_INIT, sent: 1'b0};

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        d2h_done = d2h_valid && c_q.sent && !port_rst;
        if (port_rst) begin
            c_d = CAP_INIT;
        end else if (d2h_valid) begin
            c_d.tfd = {f_error, f_status};
            if (!c_q.sent) begin
                c_d.sig  = {f_cyl_hi, f_cyl_lo, f_lba_lo, f_count};
                c_d.sent = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CAP_INIT;
        else        c_q <= c_d;
    end

    assign tfd      = c_q.tfd;
    assign sig      = c_q.sig;
    assign d2h_sent = c_q.sent;
endmodule

// File: rtl/ahci_srst_seq.sv
module ahci_srst_seq
    import ahci_srst_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 32,
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 comreset,
    input  logic                 h2d_valid,
    input  logic [7:0]           h2d_ctrl,
    input  logic [SLOT_W-1:0]    h2d_slot,
    input  logic                 h2d_clr_busy,
    input  logic [NUM_SLOTS-1:0] ci_set,
    input  logic                 d2h_valid,
    input  logic [7:0]           d2h_status,
    input  logic [7:0]           d2h_error,
    input  logic [7:0]           d2h_cyl_hi,
    input  logic [7:0]           d2h_cyl_lo,
    input  logic [7:0]           d2h_lba_lo,
    input  logic [7:0]           d2h_count,
    output logic [NUM_SLOTS-1:0] ci,
    output logic [15:0]          tfd,
    output logic [31:0]          sig,
    output logic                 busy_valid,
    output logic [SLOT_W-1:0]    busy_slot,
    output logic                 d2h_sent,
    output logic                 in_reset
);
    logic enter_rst, port_rst, clr_req, cmd_mark, d2h_done;

    ahci_srst_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .comreset  (comreset),
        .fis_valid (h2d_valid),
        .srst_bit  (h2d_ctrl[CTRL_SRST_BIT]),
        .clr_busy  (h2d_clr_busy),
        .enter_rst (enter_rst),
        .port_rst  (port_rst),
        .clr_req   (clr_req),
        .cmd_mark  (cmd_mark),
        .in_reset  (in_reset)
    );

    ahci_srst_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_rst   (port_rst),
        .clr_req    (clr_req),
        .cmd_mark   (cmd_mark),
        .d2h_done   (d2h_done),
        .slot       (h2d_slot),
        .issue      (ci_set),
        .ci         (ci),
        .busy_valid (busy_valid),
        .busy_slot  (busy_slot)
    );

    ahci_srst_sigcap u_sig (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_rst  (port_rst),
        .d2h_valid (d2h_valid),
        .f_status  (d2h_status),
        .f_error   (d2h_error),
        .f_cyl_hi  (d2h_cyl_hi),
        .f_cyl_lo  (d2h_cyl_lo),
        .f_lba_lo  (d2h_lba_lo),
        .f_count   (d2h_count),
        .d2h_done  (d2h_done),
        .tfd       (tfd),
        .sig       (sig),
        .d2h_sent  (d2h_sent)
    );

    logic unused_ok;
    assign unused_ok = ^{enter_rst, h2d_ctrl};
endmodule

// File: rtl/ahci_srst_chk.sv
module ahci_srst_chk
    import ahci_srst_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 32,
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 comreset,
    input logic                 h2d_valid,
    input logic [7:0]           h2d_ctrl,
    input logic [SLOT_W-1:0]    h2d_slot,
    input logic                 h2d_clr_busy,
    input logic [NUM_SLOTS-1:0] ci_set,
    input logic                 d2h_valid,
    input logic [7:0]           d2h_cyl_hi,
    input logic [7:0]           d2h_cyl_lo,
    input logic [7:0]           d2h_lba_lo,
    input logic [7:0]           d2h_count,
    input logic [NUM_SLOTS-1:0] ci,
    input logic [15:0]          tfd,
    input logic [31:0]          sig,
    input logic                 busy_valid,
    input logic                 d2h_sent,
    input logic                 in_reset
);
    logic srst, rel;
    assign srst = h2d_ctrl[CTRL_SRST_BIT];
    assign rel  = comreset || (in_reset && h2d_valid && !srst);

    p_enter_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_reset && h2d_valid && srst && !comreset) |=> in_reset);

    p_clear_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_reset && h2d_valid && srst && h2d_clr_busy && !comreset
         && !ci_set[h2d_slot]) |=> !ci[$past(h2d_slot)]);

    p_port_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> (ci == '0 && tfd == TFD_INIT && sig == SIG_INIT
                 && !d2h_sent && !busy_valid && !in_reset));

    p_ignore_srst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_reset && h2d_valid && srst && !comreset && ci_set == '0)
        |=> (in_reset && ci == $past(ci)));

    p_first_sig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!d2h_sent && d2h_valid && !rel) |=>
        (d2h_sent && sig == {$past(d2h_cyl_hi), $past(d2h_cyl_lo),
                             $past(d2h_lba_lo), $past(d2h_count)}));

    p_sig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (d2h_sent && !rel) |=> $stable(sig));

    p_comreset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comreset |=> (!in_reset && ci == '0));
endmodule

bind ahci_srst_seq ahci_srst_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .comreset     (comreset),
    .h2d_valid    (h2d_valid),
    .h2d_ctrl     (h2d_ctrl),
    .h2d_slot     (h2d_slot),
    .h2d_clr_busy (h2d_clr_busy),
    .ci_set       (ci_set),
    .d2h_valid    (d2h_valid),
    .d2h_cyl_hi   (d2h_cyl_hi),
    .d2h_cyl_lo   (d2h_cyl_lo),
    .d2h_lba_lo   (d2h_lba_lo),
    .d2h_count    (d2h_count),
    .ci           (ci),
    .tfd          (tfd),
    .sig          (sig),
    .busy_valid   (busy_valid),
    .d2h_sent     (d2h_sent),
    .in_reset     (in_reset)
);

// File: tb/tb_ahci_srst_seq.sv
`timescale 1ns/1ps
module tb_ahci_srst_seq;
    localparam int unsigned N  = 32;
    localparam int unsigned SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          comreset = 1'b0;
    logic          h2d_valid = 1'b0;
    logic [7:0]    h2d_ctrl = '0;
    logic [SW-1:0] h2d_slot = '0;
    logic          h2d_clr_busy = 1'b0;
    logic [N-1:0]  ci_set = '0;
    logic          d2h_valid = 1'b0;
    logic [7:0]    d2h_status = '0, d2h_error = '0, d2h_cyl_hi = '0;
    logic [7:0]    d2h_cyl_lo = '0, d2h_lba_lo = '0, d2h_count = '0;
    logic [N-1:0]  ci;
    logic [15:0]   tfd;
    logic [31:0]   sig;
    logic          busy_valid;
    logic [SW-1:0] busy_slot;
    logic          d2h_sent, in_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ahci_srst_seq #(.NUM_SLOTS(N)) dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FIL%s %s actual=%h expected=%h", "", req, act, exp);
        end
    endtask

    task automatic fis_h2d(input logic [SW-1:0] s, input logic [7:0] c,
                           input logic clr, input logic [N-1:0] iss);
        @(negedge clk);
        h2d_valid = 1'b1; h2d_slot = s; h2d_ctrl = c; h2d_clr_busy = clr;
        ci_set = iss;
        @(negedge clk);
        h2d_valid = 1'b0; h2d_ctrl = '0; h2d_clr_busy = 1'b0; ci_set = '0;
    endtask

    task automatic fis_d2h(input logic [7:0] st, er, ch, cl, ll, sc);
        @(negedge clk);
        d2h_valid = 1'b1; d2h_status = st; d2h_error = er;
        d2h_cyl_hi = ch; d2h_cyl_lo = cl; d2h_lba_lo = ll; d2h_count = sc;
        @(negedge clk);
        d2h_valid = 1'b0;
    endtask

    task automatic issue(input logic [N-1:0] m);
        @(negedge clk); ci_set = m;
        @(negedge clk); ci_set = '0;
    endtask

    task automatic t_reset_state;
        chk("R1 state", {31'b0, in_reset}, 32'd0);
        chk("R1 ci", ci, 32'h0);
        chk("R1 tfd", {16'b0, tfd}, 32'h7F);
        chk("R1 sig", sig, 32'hFFFF_FFFF);
        chk("R1 busy/sent", {30'b0, busy_valid, d2h_sent}, 32'd0);
    endtask

    task automatic t_normal_cmds;
        issue(32'h5);
        chk("R10 issue", ci, 32'h5);
        fis_h2d(5'd0, 8'hFB, 1'b0, '0);
        chk("R2 other ctrl bits stay running", {31'b0, in_reset}, 32'd0);
        chk("R9 busy mark", {26'b0, busy_valid, busy_slot}, {26'b0, 1'b1, 5'd0});
        fis_d2h(8'h50, 8'h01, 8'hEB, 8'h14, 8'h01, 8'h01);
        chk("R6 first sig", sig, 32'hEB14_0101);
        chk("R6 tfd", {16'b0, tfd}, 32'h0150);
        chk("R6 ci untouched", ci, 32'h5);
        chk("R6 busy untouched", {31'b0, busy_valid}, 32'd1);
        fis_d2h(8'h40, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44);
        chk("R7 tfd", {16'b0, tfd}, 32'h0040);
        chk("R7 sig held", sig, 32'hEB14_0101);
        chk("R7 ci retire", ci, 32'h4);
        chk("R7 busy cleared", {31'b0, busy_valid}, 32'd0);
    endtask

    task automatic t_srst_sequence;
        fis_h2d(5'd2, 8'h04, 1'b1, 32'h20);
        chk("R2 enter reset", {31'b0, in_reset}, 32'd1);
        chk("R3 R10 clear+issue", ci, 32'h20);
        fis_h2d(5'd5, 8'h0C, 1'b1, '0);
        chk("R5 stays reset", {31'b0, in_reset}, 32'd1);
        chk("R5 ci untouched", ci, 32'h20);
        fis_h2d(5'd5, 8'h08, 1'b0, '0);
        chk("R4 running", {31'b0, in_reset}, 32'd0);
        chk("R4 ci", ci, 32'h0);
        chk("R4 tfd", {16'b0, tfd}, 32'h7F);
        chk("R4 sig", sig, 32'hFFFF_FFFF);
        chk("R4 sent", {31'b0, d2h_sent}, 32'd0);
        fis_d2h(8'h50, 8'h00, 8'hAA, 8'hBB, 8'hCC, 8'hDD);
        chk("R6 after srst", sig, 32'hAABB_CCDD);
    endtask

    task automatic t_noclr_and_comreset;
        issue(32'h8);
        fis_h2d(5'd3, 8'h04, 1'b0, '0);
        chk("R3 no clr keeps ci", ci, 32'h8);
        @(negedge clk); comreset = 1'b1;
        @(negedge clk); comreset = 1'b0;
        chk("R8 running", {31'b0, in_reset}, 32'd0);
        chk("R8 ci", ci, 32'h0);
        chk("R8 sig", sig, 32'hFFFF_FFFF);
        chk("R8 sent", {31'b0, d2h_sent}, 32'd0);
        fis_d2h(8'h50, 8'h00, 8'h96, 8'h69, 8'h01, 8'h01);
        chk("R8 R6 sig after comreset", sig, 32'h9669_0101);
    endtask

    task automatic t_release_collision;
        fis_h2d(5'd1, 8'h04, 1'b0, '0);
        fis_h2d(5'd1, 8'h00, 1'b0, 32'h1);
        chk("R10 reset drops issue", ci, 32'h0);
        chk("R10 running", {31'b0, in_reset}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_normal_cmds();
        t_srst_sequence();
        t_noclr_and_comreset();
        t_release_collision();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule